// File: doc/BRIEF.md
# Font RAM Write Stream Decoder

This block sits behind a serial slave interface that has already framed the incoming bytes. Each received byte arrives with a one-cycle valid strobe, and the transfer boundaries arrive as separate start and stop pulses. The block turns the stream into write cycles for a small character-font RAM. It drives a font (segment) number, a line number within that font, a five-bit pixel row and a write enable.

The two most significant bits of every byte say what the byte means, so a host can use three packet styles. In the first, every pixel row comes with its own font and line address. In the second, the font address is sent once and each row then comes with only its line address. In the third, a single starting address is followed by any number of pixel rows. In that style the line counter advances by itself and rolls over into the next font. Once that bulk style has begun, the rest of the transfer is pixel data. Bytes that the parser cannot place are dropped and recorded in a sticky error flag.

Top module: `fontram_wr_decoder`

## Requirements
- R1: Byte class is taken from bits 7:6 while an address is expected. 11 is a font address whose value is bits 2:0. 00 is a single-row line address whose value is bits 4:0. 01 is a bulk line address whose value is bits 4:0. 10 is a data-class byte.
- R2: After a font address and a 00 line address, the next byte, whatever its top bits, produces exactly one write. That write uses the held font, the held line and wr_data equal to the byte's bits 4:0, so bits 7:5 have no effect.
- R3: After a single-row write, a 00 line address followed by a data byte writes to the new line and keeps the previous font number.
- R4: After a single-row write, a new font address followed by a line address and data re-addresses the write completely.
- R5: After a 01 line address, every byte is written, and the line number rises by one after each write.
- R6: In bulk mode, a write at line LINES_PER_FONT-1 (default 17) is followed by a write at line 0 of the next font.
- R7: In bulk mode, the write after font NUM_FONTS-1 (default 7) at its last line goes to font 0, line 0.
- R8: Once bulk mode is entered, bytes whose top bits are 11 or 00 are written as data and are not taken as addresses, until a start or stop pulse.
- R9: A start or stop pulse makes the parser expect a font address. A byte that is valid in the same cycle as the pulse is dropped and produces no write.
- R10: A non-address byte is dropped with no write, and the error flag is set, in two cases. The first is any byte other than a font address while a font address is expected. The second is a data-class byte (10) while a line address is expected. The flag then stays set until reset.
- R11: During and after reset, wr_en and err_flag are 0 and the parser expects a font address.
- R12: A write appears on the outputs, registered, in the clock cycle right after the byte that causes it. No write appears without a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | byte_data holds a received byte this cycle |
| byte_data | input | 8 | Received byte |
| xfer_start | input | 1 | One-cycle pulse at the start of a transfer |
| xfer_stop | input | 1 | One-cycle pulse at the end of a transfer |
| wr_en | output | 1 | Font RAM write enable |
| wr_seg | output | 3 | Font number of the write |
| wr_line | output | 5 | Line within the font |
| wr_data | output | 5 | Pixel row to store |
| err_flag | output | 1 | Sticky flag for dropped bytes |

## Verification
The bench goes after the bulk rollover at line 17, both into the next font and from font 7 back to font 0. A design that compared against the wrong limit would write to line 18 or stay in the same font. It feeds address-looking bytes (top bits 11 and 00) both in the data slot of the single-row style and during bulk loading. A parser that re-examined them would move the address or lose the pixel row. A start pulse arrives in the same cycle as a valid byte, and data arrives with no line address. A design that handled these wrongly would produce a stray write, or would fail to raise or fail to hold the error flag.

// File: rtl/fontwr_pkg.sv
package fontwr_pkg;

  typedef enum logic [1:0] {
    BC_SEG       = 2'd0,
    BC_LINE_WORD = 2'd1,
    BC_LINE_BULK = 2'd2,
    BC_DATA      = 2'd3
  } byte_cls_t;

  typedef enum logic [1:0] {
    ST_WANT_SEG  = 2'd0,
    ST_WANT_LINE = 2'd1,
    ST_WANT_DATA = 2'd2,
    ST_BULK      = 2'd3
  } parse_st_t;

endpackage

// File: rtl/fontwr_classify.sv
module fontwr_classify
  import fontwr_pkg::*;
(
  input  logic [1:0] tag_bits,
  output byte_cls_t  cls
);

  always_comb begin
    case (tag_bits)
      2'b11:   cls = BC_SEG;
      2'b00:   cls = BC_LINE_WORD;
      2'b01:   cls = BC_LINE_BULK;
      default: cls = BC_DATA;
    endcase
  end

endmodule

// File: rtl/fontwr_ctrl.sv
module fontwr_ctrl
  import fontwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      valid,
  input  logic      restart,
  input  byte_cls_t cls,
  output logic      ld_seg,
  output logic      ld_line,
  output logic      fire,
  output logic      bump,
  output logic      err_q
);

  parse_st_t st_q, st_d;
  logic      set_err;

  always_comb begin
    st_d    = st_q;
    ld_seg  = 1'b0;
    ld_line = 1'b0;
    fire    = 1'b0;
    bump    = 1'b0;
    set_err = 1'b0;
    if (restart) begin
      st_d = ST_WANT_SEG;
    end else if (valid) begin
      case (st_q)
        ST_WANT_SEG: begin
          if (cls == BC_SEG) begin
            ld_seg = 1'b1;
            st_d   = ST_WANT_LINE;
          end else begin
            set_err = 1'b1;
          end
        end
        ST_WANT_LINE: begin
          case (cls)
            BC_SEG:       ld_seg = 1'b1;
            BC_LINE_WORD: begin
              ld_line = 1'b1;
              st_d    = ST_WANT_DATA;
            end
            BC_LINE_BULK: begin
              ld_line = 1'b1;
              st_d    = ST_BULK;
            end
            default:      set_err = 1'b1;
          endcase
        end
        ST_WANT_DATA: begin
          fire = 1'b1;
          st_d = ST_WANT_LINE;
        end
        default: begin
          fire = 1'b1;
          bump = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_WANT_SEG;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (set_err) err_q <= 1'b1;
    end
  end

endmodule

// File: rtl/fontwr_addr.sv
module fontwr_addr #(
  parameter int NUM_FONTS      = 8,
  parameter int LINES_PER_FONT = 18,
  parameter int SEG_W          = 3,
  parameter int LINE_W         = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_seg,
  input  logic              ld_line,
  input  logic              bump,
  input  logic [SEG_W-1:0]  seg_in,
  input  logic [LINE_W-1:0] line_in,
  output logic [SEG_W-1:0]  seg_q,
  output logic [LINE_W-1:0] line_q
);

  localparam logic [SEG_W-1:0]  SEG_LAST  = SEG_W'(NUM_FONTS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES_PER_FONT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= '0;
      line_q <= '0;
    end else begin
      if (ld_seg)  seg_q  <= seg_in;
      if (ld_line) line_q <= line_in;
      if (bump) begin
        if (line_q >= LINE_LAST) begin
          line_q <= '0;
          seg_q  <= (seg_q >= SEG_LAST) ? '0 : seg_q + 1'b1;
        end else begin
          line_q <= line_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fontwr_wport.sv
module fontwr_wport #(
  parameter int SEG_W  = 3,
  parameter int LINE_W = 5,
  parameter int DATA_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [SEG_W-1:0]  seg_in,
  input  logic [LINE_W-1:0] line_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              wr_en,
  output logic [SEG_W-1:0]  wr_seg,
  output logic [LINE_W-1:0] wr_line,
  output logic [DATA_W-1:0] wr_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_seg  <= '0;
      wr_line <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= fire;
      if (fire) begin
        wr_seg  <= seg_in;
        wr_line <= line_in;
        wr_data <= data_in;
      end
    end
  end

endmodule

// File: rtl/fontram_wr_decoder.sv
module fontram_wr_decoder
  import fontwr_pkg::*;
#(
  parameter  int NUM_FONTS      = 8,
  parameter  int LINES_PER_FONT = 18,
  parameter  int DATA_W         = 5,
  localparam int SEG_W          = $clog2(NUM_FONTS),
  localparam int LINE_W         = $clog2(LINES_PER_FONT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              xfer_start,
  input  logic              xfer_stop,
  output logic              wr_en,
  output logic [SEG_W-1:0]  wr_seg,
  output logic [LINE_W-1:0] wr_line,
  output logic [DATA_W-1:0] wr_data,
  output logic              err_flag
);

  byte_cls_t         cls;
  logic              ld_seg, ld_line, fire, bump;
  logic [SEG_W-1:0]  seg_cur;
  logic [LINE_W-1:0] line_cur;
  logic              unused_bits;

  assign unused_bits = ^byte_data;

  fontwr_classify u_cls (
    .tag_bits (byte_data[7:6]),
    .cls      (cls)
  );

  fontwr_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .valid   (byte_valid),
    .restart (xfer_start | xfer_stop),
    .cls     (cls),
    .ld_seg  (ld_seg),
    .ld_line (ld_line),
    .fire    (fire),
    .bump    (bump),
    .err_q   (err_flag)
  );

  fontwr_addr #(
    .NUM_FONTS      (NUM_FONTS),
    .LINES_PER_FONT (LINES_PER_FONT),
    .SEG_W          (SEG_W),
    .LINE_W         (LINE_W)
  ) u_addr (
    .clk     (clk),
    .rst     (rst),
    .ld_seg  (ld_seg),
    .ld_line (ld_line),
    .bump    (bump),
    .seg_in  (byte_data[SEG_W-1:0]),
    .line_in (byte_data[LINE_W-1:0]),
    .seg_q   (seg_cur),
    .line_q  (line_cur)
  );

  fontwr_wport #(
    .SEG_W  (SEG_W),
    .LINE_W (LINE_W),
    .DATA_W (DATA_W)
  ) u_wport (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .seg_in  (seg_cur),
    .line_in (line_cur),
    .data_in (byte_data[DATA_W-1:0]),
    .wr_en   (wr_en),
    .wr_seg  (wr_seg),
    .wr_line (wr_line),
    .wr_data (wr_data)
  );

endmodule

// File: rtl/fontwr_chk.sv
module fontwr_chk #(
  parameter int DATA_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_valid,
  input logic [DATA_W-1:0] byte_lo,
  input logic              xfer_start,
  input logic              xfer_stop,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              err_flag
);

  // R12: every write follows a received byte
  p_wr_follows_byte_r12: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(byte_valid));

  // R2: written pixel row is the low bits of the causing byte
  p_data_low_bits_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data == $past(byte_lo)));

  // R9: a restart pulse never yields a write in the next cycle
  p_restart_drops_r9: assert property (@(posedge clk) disable iff (rst)
    $past(xfer_start || xfer_stop) |-> !wr_en);

  // R10: the error flag holds once set
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  // R10: the flag rises only on a dropped byte
  p_err_on_drop_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> ($past(byte_valid) && !wr_en));

endmodule

bind fontram_wr_decoder fontwr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .byte_valid (byte_valid),
  .byte_lo    (byte_data[DATA_W-1:0]),
  .xfer_start (xfer_start),
  .xfer_stop  (xfer_stop),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .err_flag   (err_flag)
);

// File: tb/fontram_wr_decoder_tb_top.sv
`timescale 1ns/1ps
module fontram_wr_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       xfer_start = 1'b0;
  logic       xfer_stop = 1'b0;
  logic       wr_en;
  logic [2:0] wr_seg;
  logic [4:0] wr_line;
  logic [4:0] wr_data;
  logic       err_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R11";

  logic [12:0] q_exp[$];
  string       q_req[$];

  always #2.5 clk = ~clk;

  fontram_wr_decoder dut_i (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .xfer_start(xfer_start), .xfer_stop(xfer_stop), .wr_en(wr_en),
    .wr_seg(wr_seg), .wr_line(wr_line), .wr_data(wr_data), .err_flag(err_flag)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_wr(int seg, int line, int data, string req);
    q_exp.push_back({seg[2:0], line[4:0], data[4:0]});
    q_req.push_back(req);
  endtask

  task automatic send(logic [7:0] b, bit expw, string req);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
    check(wr_en == expw, req, "write in next cycle", int'(wr_en), int'(expw));
  endtask

  task automatic pulse(bit is_stop);
    @(negedge clk);
    if (is_stop) xfer_stop = 1'b1; else xfer_start = 1'b1;
    @(negedge clk);
    xfer_stop = 1'b0;
    xfer_start = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (q_exp.size() == 0) begin
        check(1'b0, cur_req, "unexpected write", {wr_seg, wr_line, wr_data}, 0);
      end else begin
        logic [12:0] e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        check({wr_seg, wr_line, wr_data} == e, r, "write seg/line/data",
              {wr_seg, wr_line, wr_data}, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(wr_en == 1'b0, "R11", "wr_en in reset", int'(wr_en), 0);
    check(err_flag == 1'b0, "R11", "err in reset", int'(err_flag), 0);
    rst = 1'b0;
    @(negedge clk);
    check(wr_en == 1'b0 && err_flag == 1'b0, "R11", "after reset", int'({wr_en, err_flag}), 0);

    // R2 / R1: full addressing, top data bits ignored
    cur_req = "R2";
    pulse(1'b0);
    send(8'hC3, 1'b0, "R1");
    send(8'h05, 1'b0, "R1");
    expect_wr(3, 5, 5'h1A, "R2");
    send(8'hFA, 1'b1, "R12");

    // R3: line-only addressing keeps font 3; data slot with top bits 11
    cur_req = "R3";
    send(8'h07, 1'b0, "R3");
    expect_wr(3, 7, 5'h11, "R3");
    send(8'h11, 1'b1, "R3");
    send(8'h00, 1'b0, "R3");
    expect_wr(3, 0, 5'h00, "R2");
    send(8'hE0, 1'b1, "R2");

    // R4: back to full addressing
    cur_req = "R4";
    send(8'hC6, 1'b0, "R4");
    send(8'h02, 1'b0, "R4");
    expect_wr(6, 2, 5'h09, "R4");
    send(8'h09, 1'b1, "R4");

    // R5 / R6 / R8: bulk from font 1 line 16
    cur_req = "R5";
    send(8'hC1, 1'b0, "R5");
    send(8'h50, 1'b0, "R5");
    expect_wr(1, 16, 5'h01, "R5");
    send(8'h01, 1'b1, "R5");
    expect_wr(1, 17, 5'h02, "R5");
    send(8'h02, 1'b1, "R5");
    expect_wr(2, 0, 5'h03, "R6");
    send(8'h03, 1'b1, "R6");
    cur_req = "R8";
    expect_wr(2, 1, 5'h05, "R8");
    send(8'hC5, 1'b1, "R8");
    expect_wr(2, 2, 5'h0A, "R8");
    send(8'h0A, 1'b1, "R8");

    // R9 / R10: stop then data with no address
    cur_req = "R9";
    pulse(1'b1);
    send(8'h04, 1'b0, "R9");
    @(negedge clk);
    check(err_flag == 1'b1, "R10", "err after orphan data", int'(err_flag), 1);

    // R7: bulk wrap from last font
    cur_req = "R7";
    pulse(1'b0);
    send(8'hC7, 1'b0, "R7");
    send(8'h51, 1'b0, "R7");
    expect_wr(7, 17, 5'h1F, "R7");
    send(8'h1F, 1'b1, "R7");
    expect_wr(0, 0, 5'h10, "R7");
    send(8'h10, 1'b1, "R7");
    check(err_flag == 1'b1, "R10", "err sticky", int'(err_flag), 1);

    // R10 fresh: data-class byte where a line is expected
    do_reset();
    @(negedge clk);
    check(err_flag == 1'b0, "R11", "err cleared by reset", int'(err_flag), 0);
    cur_req = "R10";
    pulse(1'b0);
    send(8'hC2, 1'b0, "R10");
    send(8'h8F, 1'b0, "R10");
    @(negedge clk);
    check(err_flag == 1'b1, "R10", "err on data-class byte", int'(err_flag), 1);
    send(8'h03, 1'b0, "R10");
    expect_wr(2, 3, 5'h06, "R10");
    send(8'h06, 1'b1, "R10");

    // R9: byte in same cycle as start is dropped; parser reset
    cur_req = "R9";
    send(8'hC4, 1'b0, "R9");
    send(8'h41, 1'b0, "R9");
    @(negedge clk);
    xfer_start = 1'b1;
    byte_valid = 1'b1;
    byte_data  = 8'h03;
    @(negedge clk);
    xfer_start = 1'b0;
    byte_valid = 1'b0;
    check(wr_en == 1'b0, "R9", "byte with start dropped", int'(wr_en), 0);
    send(8'h02, 1'b0, "R9");
    send(8'hC4, 1'b0, "R9");
    send(8'h01, 1'b0, "R9");
    expect_wr(4, 1, 5'h03, "R9");
    send(8'h03, 1'b1, "R9");

    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R12", "missing writes", q_exp.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R12 actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule